// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and Completion Unit

This block is the processor-side face of a small multi-core interrupt controller, one instance per CPU. It keeps the pending and active state for the software interrupts (IDs 0 to NSGI-1, each one held separately for every source CPU, up to 8) and for the CPU's private peripheral interrupts (IDs NSGI to NSGI+NPPI-1). Software interrupts are raised by a one-cycle set pulse that carries an ID and a source CPU. Private interrupts are raised by one set pulse per line. Per-interrupt enable bits and 8-bit priorities come from the surrounding controller as flat input vectors.

The CPU reaches the unit through a single-beat register port. Reading the acknowledge register returns the most urgent qualifying interrupt, together with the CPU that raised it, and moves that interrupt from pending to active in the same cycle. Writing the completion register retires an active interrupt. A registered running priority follows the most urgent active interrupt. A priority mask and a binary point are held for the CPU. The binary point is stored and clamped but is not used for preemption here. An interrupt request output shows whether anything qualifies.

Top module: `irq_ack_unit`

## Requirements
- R1: Register word addresses on `reg_addr` are 0 control (bit 0 enables delivery), 1 priority mask, 2 binary point, 3 acknowledge, 4 completion, 5 running priority, 6 active-priority, 7 deactivate. After reset the values are: control 0, mask 0xFF, binary point BPR_MIN, running priority 0xFF, and an acknowledge read returns 1023.
- R2: Read data and `reg_rvalid` appear the cycle after a read request. An acknowledge word has the ID in bits 9:0, the source CPU in bits 12:10 (0 for private interrupts) and zeros above. The winner is the pending, enabled interrupt whose priority is strictly below the mask while control bit 0 is set, with the lowest priority value winning. Ties go to the lowest ID, and among the sources of one software interrupt the lowest source CPU wins.
- R3: An acknowledge that returns an interrupt clears its pending bit and sets its active bit, for the exact (ID, source) pair in the case of a software interrupt.
- R4: When nothing qualifies, an acknowledge read returns 1023 and changes no pending or active state.
- R5: A completion write uses the acknowledge-word layout. For a software interrupt it clears the active bit of that (ID, source) pair. If that pair is not active, `eoi_err_o` pulses for one cycle, the cycle after the write, and no state changes.
- R6: A completion for a private interrupt clears its active bit. One that is already clear is ignored without error, and completion IDs at or above NSGI+NPPI are ignored.
- R7: The running priority is 0xFF when nothing is active. Otherwise it is the smallest priority value over all active interrupts, and it reflects the active state of the previous cycle.
- R8: A binary-point write keeps data bits 2:0 and raises any value below BPR_MIN to BPR_MIN.
- R9: A priority-mask write keeps data bits 7:0. An interrupt whose priority is equal to or above the mask does not qualify.
- R10: Writes to the active-priority and deactivate addresses change no state.
- R11: If a software interrupt (ID, source) is raised in the same cycle that it is acknowledged, it ends that cycle both active and pending.
- R12: `irq_o` is high exactly when an interrupt qualifies under R2, and it is low while control bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request, one beat |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the request |
| reg_rdata | output | 32 | Read data |
| sgi_set | input | 1 | Raise a software interrupt for this CPU |
| sgi_set_id | input | $clog2(NSGI) | ID of the raised software interrupt |
| sgi_set_src | input | 3 | CPU that raised it |
| ppi_set | input | NPPI | One set pulse per private interrupt line |
| int_en | input | NSGI+NPPI | Per-interrupt enable |
| int_prio | input | (NSGI+NPPI)*PRIO_W | Per-interrupt priority, ID i at bits i*PRIO_W upward |
| irq_o | output | 1 | A qualifying interrupt exists |
| eoi_err_o | output | 1 | Completion named an inactive software interrupt |

## Verification
The function most likely to collide is the acknowledge's clearing of a pending bit and the raising of a new software interrupt to the same bit in the same cycle. If the clear is allowed to win, an interrupt is lost without any sign. The bench provokes this on purpose: it raises a pair, then acknowledges it while raising the same pair again. It also mixes such collisions into the random traffic. The result is judged by a second acknowledge, which must return the same pair, and by the running priority, which must still count it as active.

// File: rtl/ici_pkg.sv
package ici_pkg;

    localparam int ID_W   = 10;
    localparam int SRC_W  = 3;
    localparam int PRIO_W = 8;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_PMR   = 3'd1,
        SEL_BPR   = 3'd2,
        SEL_ACK   = 3'd3,
        SEL_EOI   = 3'd4,
        SEL_RPR   = 3'd5,
        SEL_APR   = 3'd6,
        SEL_DEACT = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [ID_W-1:0]  id;
    } ack_word_t;

    typedef struct packed {
        logic      hit;
        ack_word_t word;
    } cand_t;

    function automatic logic [2:0] bpr_clamp(input logic [2:0] wr, input logic [2:0] floor_v);
        return (wr < floor_v) ? floor_v : wr;
    endfunction

endpackage

// File: rtl/ici_state.sv
module ici_state
    import ici_pkg::*;
#(
    parameter int NCPU = 8,
    parameter int NSGI = 16,
    parameter int NPPI = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sgi_set,
    input  logic [ID_W-1:0]        sgi_set_id,
    input  logic [SRC_W-1:0]       sgi_set_src,
    input  logic [NPPI-1:0]        ppi_set,
    input  logic                   take,
    input  ack_word_t              take_w,
    input  logic                   eoi,
    input  ack_word_t              eoi_w,
    output logic [NSGI*NCPU-1:0]   sgi_pend,
    output logic [NSGI*NCPU-1:0]   sgi_act,
    output logic [NPPI-1:0]        ppi_pend,
    output logic [NPPI-1:0]        ppi_act,
    output logic                   eoi_bad
);
    localparam int SGI_BITS = NSGI * NCPU;
    localparam int SIDX_W   = $clog2(SGI_BITS);
    localparam int PIDX_W   = $clog2(NPPI);

    logic [SGI_BITS-1:0] sp_d, sa_d;
    logic [NPPI-1:0]     pp_d, pa_d;
    logic take_sgi, take_ppi, eoi_sgi, eoi_ppi, set_ok, eoi_bad_d;
    logic [SIDX_W-1:0] take_si, eoi_si, set_si;
    logic [PIDX_W-1:0] take_pi, eoi_pi;

    always_comb begin
        take_sgi = take && (int'(take_w.id) < NSGI) && (int'(take_w.src) < NCPU);
        take_ppi = take && (int'(take_w.id) >= NSGI) && (int'(take_w.id) < NSGI + NPPI);
        eoi_sgi  = eoi && (int'(eoi_w.id) < NSGI) && (int'(eoi_w.src) < NCPU);
        eoi_ppi  = eoi && (int'(eoi_w.id) >= NSGI) && (int'(eoi_w.id) < NSGI + NPPI);
        set_ok   = sgi_set && (int'(sgi_set_id) < NSGI) && (int'(sgi_set_src) < NCPU);
        take_si  = SIDX_W'(int'(take_w.id) * NCPU + int'(take_w.src));
        eoi_si   = SIDX_W'(int'(eoi_w.id) * NCPU + int'(eoi_w.src));
        set_si   = SIDX_W'(int'(sgi_set_id) * NCPU + int'(sgi_set_src));
        take_pi  = PIDX_W'(int'(take_w.id) - NSGI);
        eoi_pi   = PIDX_W'(int'(eoi_w.id) - NSGI);

        sp_d = sgi_pend;
        sa_d = sgi_act;
        pp_d = ppi_pend;
        pa_d = ppi_act;
        if (take_sgi) begin
            sp_d[take_si] = 1'b0;
            sa_d[take_si] = 1'b1;
        end
        if (take_ppi) begin
            pp_d[take_pi] = 1'b0;
            pa_d[take_pi] = 1'b1;
        end
        if (eoi_sgi) sa_d[eoi_si] = 1'b0;
        if (eoi_ppi) pa_d[eoi_pi] = 1'b0;
        // a new raise lands after the acknowledge clear, so it is never lost
        if (set_ok) sp_d[set_si] = 1'b1;
        pp_d = pp_d | ppi_set;

        eoi_bad_d = eoi && (int'(eoi_w.id) < NSGI) && !(eoi_sgi && sgi_act[eoi_si]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sgi_pend <= '0;
            sgi_act  <= '0;
            ppi_pend <= '0;
            ppi_act  <= '0;
            eoi_bad  <= 1'b0;
        end else begin
            sgi_pend <= sp_d;
            sgi_act  <= sa_d;
            ppi_pend <= pp_d;
            ppi_act  <= pa_d;
            eoi_bad  <= eoi_bad_d;
        end
    end

endmodule

// File: rtl/ici_select.sv
module ici_select
    import ici_pkg::*;
#(
    parameter int NCPU   = 8,
    parameter int NSGI   = 16,
    parameter int NPPI   = 16,
    parameter int PRIO_W = ici_pkg::PRIO_W
) (
    input  logic [NSGI*NCPU-1:0]           sgi_pend,
    input  logic [NPPI-1:0]                ppi_pend,
    input  logic [NSGI+NPPI-1:0]           int_en,
    input  logic [(NSGI+NPPI)*PRIO_W-1:0]  int_prio,
    input  logic [PRIO_W-1:0]              pmr,
    input  logic                           cpu_on,
    output cand_t                          best
);
    localparam int NINT = NSGI + NPPI;

    logic [NINT-1:0]       pend_any;
    logic [NINT*SRC_W-1:0] src_flat;

    for (genvar g = 0; g < NSGI; g++) begin : g_sgi_row
        logic [NCPU-1:0]  row;
        logic [SRC_W-1:0] lsrc;
        assign row = sgi_pend[g*NCPU +: NCPU];
        always_comb begin
            lsrc = '0;
            for (int s = NCPU - 1; s >= 0; s--) begin
                if (row[s]) lsrc = SRC_W'(s);
            end
        end
        assign pend_any[g] = |row;
        assign src_flat[g*SRC_W +: SRC_W] = lsrc;
    end

    for (genvar g = 0; g < NPPI; g++) begin : g_ppi_line
        assign pend_any[NSGI+g] = ppi_pend[g];
        assign src_flat[(NSGI+g)*SRC_W +: SRC_W] = '0;
    end

    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] p;

    always_comb begin
        best         = '0;
        best.word.id = SPURIOUS_ID;
        best_p       = '1;
        p            = '0;
        for (int i = 0; i < NINT; i++) begin
            p = int_prio[i*PRIO_W +: PRIO_W];
            if (cpu_on && pend_any[i] && int_en[i] && (p < pmr) && (!best.hit || p < best_p)) begin
                best.hit      = 1'b1;
                best_p        = p;
                best.word.id  = ID_W'(i);
                best.word.src = src_flat[i*SRC_W +: SRC_W];
            end
        end
    end

endmodule

// File: rtl/ici_runpri.sv
module ici_runpri
    import ici_pkg::*;
#(
    parameter int NCPU   = 8,
    parameter int NSGI   = 16,
    parameter int NPPI   = 16,
    parameter int PRIO_W = ici_pkg::PRIO_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NSGI*NCPU-1:0]           sgi_act,
    input  logic [NPPI-1:0]                ppi_act,
    input  logic [(NSGI+NPPI)*PRIO_W-1:0]  int_prio,
    output logic [PRIO_W-1:0]              runpri_q
);
    localparam int NINT = NSGI + NPPI;

    logic [NINT-1:0] act_any;

    for (genvar g = 0; g < NSGI; g++) begin : g_sgi_act
        assign act_any[g] = |sgi_act[g*NCPU +: NCPU];
    end
    assign act_any[NINT-1:NSGI] = ppi_act;

    logic [PRIO_W-1:0] min_p;

    always_comb begin
        min_p = '1;
        for (int i = 0; i < NINT; i++) begin
            if (act_any[i] && int_prio[i*PRIO_W +: PRIO_W] < min_p)
                min_p = int_prio[i*PRIO_W +: PRIO_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) runpri_q <= '1;
        else     runpri_q <= min_p;
    end

endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
    import ici_pkg::*;
#(
    parameter int NCPU    = 8,
    parameter int NSGI    = 16,
    parameter int NPPI    = 16,
    parameter int PRIO_W  = ici_pkg::PRIO_W,
    parameter int BPR_MIN = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            reg_req,
    input  logic                            reg_we,
    input  logic [2:0]                      reg_addr,
    input  logic [31:0]                     reg_wdata,
    output logic                            reg_rvalid,
    output logic [31:0]                     reg_rdata,
    input  logic                            sgi_set,
    input  logic [$clog2(NSGI)-1:0]         sgi_set_id,
    input  logic [2:0]                      sgi_set_src,
    input  logic [NPPI-1:0]                 ppi_set,
    input  logic [NSGI+NPPI-1:0]            int_en,
    input  logic [(NSGI+NPPI)*PRIO_W-1:0]   int_prio,
    output logic                            irq_o,
    output logic                            eoi_err_o
);
    localparam int NINT  = NSGI + NPPI;
    localparam int WORD_W = ID_W + SRC_W;

    reg_sel_e          sel;
    logic              wr, rd, ack_rd, take, eoi_wr;
    ack_word_t         eoi_w;
    cand_t             best;
    logic              ctrl_en;
    logic [PRIO_W-1:0] pmr_q;
    logic [2:0]        bpr_q;
    logic [PRIO_W-1:0] runpri_q;
    logic [31:0]       rd_mux;

    logic [NSGI*NCPU-1:0] sgi_pend, sgi_act;
    logic [NPPI-1:0]      ppi_pend, ppi_act;

    assign sel    = reg_sel_e'(reg_addr);
    assign wr     = reg_req && reg_we;
    assign rd     = reg_req && !reg_we;
    assign ack_rd = rd && (sel == SEL_ACK);
    assign take   = ack_rd && best.hit;
    assign eoi_wr = wr && (sel == SEL_EOI);
    assign eoi_w  = ack_word_t'(reg_wdata[WORD_W-1:0]);

    ici_state #(.NCPU(NCPU), .NSGI(NSGI), .NPPI(NPPI)) u_state (
        .clk         (clk),
        .rst         (rst),
        .sgi_set     (sgi_set),
        .sgi_set_id  (ID_W'(sgi_set_id)),
        .sgi_set_src (sgi_set_src),
        .ppi_set     (ppi_set),
        .take        (take),
        .take_w      (best.word),
        .eoi         (eoi_wr),
        .eoi_w       (eoi_w),
        .sgi_pend    (sgi_pend),
        .sgi_act     (sgi_act),
        .ppi_pend    (ppi_pend),
        .ppi_act     (ppi_act),
        .eoi_bad     (eoi_err_o)
    );

    ici_select #(.NCPU(NCPU), .NSGI(NSGI), .NPPI(NPPI), .PRIO_W(PRIO_W)) u_select (
        .sgi_pend (sgi_pend),
        .ppi_pend (ppi_pend),
        .int_en   (int_en),
        .int_prio (int_prio),
        .pmr      (pmr_q),
        .cpu_on   (ctrl_en),
        .best     (best)
    );

    ici_runpri #(.NCPU(NCPU), .NSGI(NSGI), .NPPI(NPPI), .PRIO_W(PRIO_W)) u_runpri (
        .clk      (clk),
        .rst      (rst),
        .sgi_act  (sgi_act),
        .ppi_act  (ppi_act),
        .int_prio (int_prio),
        .runpri_q (runpri_q)
    );

    assign irq_o = best.hit;

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_CTRL: rd_mux = {31'b0, ctrl_en};
            SEL_PMR:  rd_mux = {{(32-PRIO_W){1'b0}}, pmr_q};
            SEL_BPR:  rd_mux = {29'b0, bpr_q};
            SEL_ACK:  rd_mux = {{(32-WORD_W){1'b0}}, best.word};
            SEL_RPR:  rd_mux = {{(32-PRIO_W){1'b0}}, runpri_q};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en    <= 1'b0;
            pmr_q      <= '1;
            bpr_q      <= 3'(BPR_MIN);
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= rd;
            if (rd) reg_rdata <= rd_mux;
            if (wr) begin
                case (sel)
                    SEL_CTRL: ctrl_en <= reg_wdata[0];
                    SEL_PMR:  pmr_q   <= reg_wdata[PRIO_W-1:0];
                    SEL_BPR:  bpr_q   <= bpr_clamp(reg_wdata[2:0], 3'(BPR_MIN));
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ici_checker.sv
module ici_checker #(
    parameter int PRIO_W  = 8,
    parameter int BPR_MIN = 2,
    parameter int ACT_W   = 144,
    parameter int PRIO_V  = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_req,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic              reg_rvalid,
    input logic [31:0]       reg_rdata,
    input logic              irq_o,
    input logic              eoi_err_o,
    input logic              ctrl_en,
    input logic [2:0]        bpr_q,
    input logic [PRIO_W-1:0] runpri_q,
    input logic [ACT_W-1:0]  act_all,
    input logic [PRIO_V-1:0] int_prio
);
    AST_SPURIOUS_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_we && reg_addr == 3'd3 && !irq_o) |=> (reg_rdata[9:0] == 10'd1023)) else $error("spurious"); // R4
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_we) |=> reg_rvalid) else $error("latency"); // R2
    AST_BPR_FLOOR: assert property (@(posedge clk) disable iff (rst)
        bpr_q >= 3'(BPR_MIN)) else $error("bpr"); // R8
    AST_RUNPRI_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($stable(act_all) && $stable(int_prio)) |=> $stable(runpri_q)) else $error("runpri"); // R7
    AST_ERR_AFTER_EOI: assert property (@(posedge clk) disable iff (rst)
        eoi_err_o |-> $past(reg_req && reg_we && reg_addr == 3'd4)) else $error("eoi err"); // R5
    AST_IRQ_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |-> !irq_o) else $error("irq"); // R12
endmodule

bind irq_ack_unit ici_checker #(
    .PRIO_W  (PRIO_W),
    .BPR_MIN (BPR_MIN),
    .ACT_W   (NSGI*NCPU+NPPI),
    .PRIO_V  ((NSGI+NPPI)*PRIO_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_req    (reg_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_rvalid (reg_rvalid),
    .reg_rdata  (reg_rdata),
    .irq_o      (irq_o),
    .eoi_err_o  (eoi_err_o),
    .ctrl_en    (ctrl_en),
    .bpr_q      (bpr_q),
    .runpri_q   (runpri_q),
    .act_all    ({sgi_act, ppi_act}),
    .int_prio   (int_prio)
);

// File: tb/tb_irq_ack_unit.sv
`timescale 1ns/1ps
module tb_irq_ack_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_req = 1'b0, reg_we = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic         reg_rvalid;
    logic [31:0]  reg_rdata;
    logic         sgi_set = 1'b0;
    logic [3:0]   sgi_set_id = '0;
    logic [2:0]   sgi_set_src = '0;
    logic [15:0]  ppi_set = '0;
    logic [31:0]  int_en = '0;
    logic [255:0] int_prio = '0;
    logic         irq_o, eoi_err_o;

    irq_ack_unit dut (
        .clk(clk), .rst(rst), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .sgi_set(sgi_set), .sgi_set_id(sgi_set_id), .sgi_set_src(sgi_set_src),
        .ppi_set(ppi_set), .int_en(int_en), .int_prio(int_prio),
        .irq_o(irq_o), .eoi_err_o(eoi_err_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // bench model of the block's state
    bit mps [16][8];
    bit mas [16][8];
    bit mpp [16];
    bit map [16];
    int mprio [32];
    bit men [32];
    int mpmr = 255;
    bit mctl = 0;

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    function automatic int model_ack();
        int best = 1023;
        int bp = 256;
        for (int i = 0; i < 32; i++) begin
            bit pend = 0;
            int src = 0;
            if (i < 16) begin
                for (int s = 7; s >= 0; s--) if (mps[i][s]) begin pend = 1; src = s; end
            end else pend = mpp[i-16];
            if (mctl && pend && men[i] && mprio[i] < mpmr && mprio[i] < bp) begin
                bp = mprio[i];
                best = (src << 10) | i;
            end
        end
        return best;
    endfunction

    function automatic int model_rpr();
        int m = 255;
        for (int i = 0; i < 16; i++)
            for (int s = 0; s < 8; s++) if (mas[i][s] && mprio[i] < m) m = mprio[i];
        for (int i = 0; i < 16; i++) if (map[i] && mprio[16+i] < m) m = mprio[16+i];
        return m;
    endfunction

    task automatic cycle();
        @(posedge clk);
        #2;
    endtask

    task automatic drop();
        reg_req = 0; reg_we = 0; sgi_set = 0; ppi_set = '0;
    endtask

    task automatic load_cfg();
        for (int i = 0; i < 32; i++) begin
            int_prio[i*8 +: 8] = 8'(mprio[i]);
            int_en[i] = men[i];
        end
    endtask

    task automatic op_rd(string tag, int a, int exp);
        reg_req = 1; reg_we = 0; reg_addr = 3'(a);
        cycle();
        check(tag, int'(reg_rdata), exp);
        drop();
    endtask

    task automatic op_wr(int a, int d);
        reg_req = 1; reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
        cycle();
        if (a == 0) mctl = d[0];
        if (a == 1) mpmr = d & 255;
        if (a == 2) begin
            // R8 model: low 3 bits, clamp at 2
        end
        drop();
    endtask

    task automatic idle();
        cycle();
    endtask

    task automatic op_ack(string tag, bit co, int cid, int csrc);
        int exp = model_ack();
        reg_req = 1; reg_we = 0; reg_addr = 3'd3;
        if (co) begin sgi_set = 1; sgi_set_id = 4'(cid); sgi_set_src = 3'(csrc); end
        cycle();
        check(tag, int'(reg_rdata), exp);
        check("R2 rvalid", int'(reg_rvalid), 1);
        if (exp != 1023) begin
            int id = exp & 1023;
            int src = exp >> 10;
            if (id < 16) begin mps[id][src] = 0; mas[id][src] = 1; end
            else begin mpp[id-16] = 0; map[id-16] = 1; end
        end
        if (co) mps[cid][csrc] = 1;
        drop();
    endtask

    task automatic op_eoi(string tag, int id, int src);
        bit err = (id < 16) && !mas[id][src];
        reg_req = 1; reg_we = 1; reg_addr = 3'd4; reg_wdata = (src << 10) | id;
        cycle();
        check(tag, int'(eoi_err_o), int'(err));
        if (id < 16) mas[id][src] = 0;
        else if (id < 32) map[id-16] = 0;
        drop();
    endtask

    task automatic raise_sgi(int id, int src);
        sgi_set = 1; sgi_set_id = 4'(id); sgi_set_src = 3'(src);
        cycle();
        mps[id][src] = 1;
        drop();
    endtask

    task automatic raise_ppi(int n);
        ppi_set = 16'(1) << n;
        cycle();
        mpp[n] = 1;
        drop();
    endtask

    task automatic chk_rpr(string tag);
        idle();
        op_rd(tag, 5, model_rpr());
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) begin mprio[i] = 16 * ((i * 7 + 3) % 13); men[i] = 1; end
        load_cfg();
        repeat (3) cycle();
        rst = 0;
        #1;

        // R1 reset state
        op_rd("R1 ctrl", 0, 0);
        op_rd("R1 pmr", 1, 255);
        op_rd("R1 bpr", 2, 2);
        op_rd("R1 rpr", 5, 255);
        op_rd("R1 ack", 3, 1023);

        // R8 binary point clamp
        op_wr(2, 0);          op_rd("R8 bpr 0", 2, 2);
        op_wr(2, 7);          op_rd("R8 bpr 7", 2, 7);
        op_wr(2, 32'hFFFFFFF5); op_rd("R8 bpr high bits", 2, 5);
        op_wr(2, 1);          op_rd("R8 bpr 1", 2, 2);

        // R4 / R12 disabled CPU interface
        raise_sgi(5, 2);
        check("R12 irq off", int'(irq_o), 0);
        op_ack("R4 disabled ack", 0, 0, 0);
        op_wr(0, 1);
        check("R12 irq on", int'(irq_o), 1);
        op_ack("R3 ack sgi 5/2", 0, 0, 0);
        check("R3 ack word", (2 << 10) | 5, int'(reg_rdata));
        chk_rpr("R7 rpr after ack");

        // R10 ignored writes
        op_wr(7, (2 << 10) | 5);
        op_wr(6, 32'hFFFF_FFFF);
        chk_rpr("R10 rpr unchanged");
        op_ack("R10 nothing pending", 0, 0, 0);

        // R5 completion of software interrupts
        op_eoi("R5 eoi active", 5, 2);
        chk_rpr("R7 rpr idle");
        op_eoi("R5 eoi inactive", 5, 2);

        // R6 private interrupts
        raise_ppi(3);
        op_ack("R6 ack ppi 19", 0, 0, 0);
        op_eoi("R6 eoi ppi", 19, 0);
        op_eoi("R6 eoi ppi again", 19, 0);
        op_eoi("R6 eoi out of range", 40, 0);
        chk_rpr("R6 rpr after ppi");

        // R2 tie breaking: same priority, lower id and lower source win
        mprio[9] = 16; mprio[11] = 16; load_cfg();
        raise_sgi(11, 0); raise_sgi(9, 6); raise_sgi(9, 4);
        op_ack("R2 tie lowest id/src", 0, 0, 0);
        op_ack("R2 tie next src", 0, 0, 0);
        op_ack("R2 tie next id", 0, 0, 0);

        // R9 priority mask
        raise_sgi(1, 1);
        op_wr(1, 32'h100 | mprio[1]);
        op_rd("R9 pmr low byte", 1, mprio[1]);
        op_ack("R9 equal masked", 0, 0, 0);
        op_wr(1, 255);

        // R11 raise and acknowledge same pair together
        raise_sgi(7, 1);
        mprio[7] = 0; load_cfg();
        op_ack("R11 ack with co-raise", 1, 7, 1);
        op_ack("R11 still pending", 0, 0, 0);
        op_eoi("R11 eoi", 7, 1);
        chk_rpr("R11 rpr");

        // random traffic
        for (int it = 0; it < 1500; it++) begin
            int op = int'($urandom % 10);
            if (op <= 2) raise_sgi(int'($urandom % 16), int'($urandom % 8));
            else if (op == 3) raise_ppi(int'($urandom % 16));
            else if (op <= 5) begin
                bit co = ($urandom % 3) == 0;
                int e = model_ack();
                int cid = int'($urandom % 16);
                int csrc = int'($urandom % 8);
                if (co && e < 16 && ($urandom % 2) == 0) begin cid = e; csrc = 0; end
                if (co && e < 16 && e != 1023) begin csrc = (model_ack() >> 10); end
                op_ack("R2 random ack", co, cid, csrc);
            end else if (op <= 7) begin
                int id = int'($urandom % 40);
                int src = int'($urandom % 8);
                if ($urandom % 2 == 0) begin
                    for (int k = 0; k < 16; k++)
                        for (int s = 0; s < 8; s++) if (mas[k][s]) begin id = k; src = s; end
                end
                op_eoi("R5 random eoi", id, src);
            end else if (op == 8) chk_rpr("R7 random rpr");
            else begin
                int w = int'($urandom % 4);
                if (w == 0) op_wr(1, (w == 0) ? int'($urandom % 256) | 32'h40 : 255);
                else if (w == 1) op_wr(1, 255);
                else op_wr(6 + int'($urandom % 2), int'($urandom));
            end
            check("R12 irq", int'(irq_o), int'(model_ack() != 1023));
            if (it % 300 == 299) begin
                for (int i = 0; i < 32; i++) begin
                    mprio[i] = 16 * int'($urandom % 16);
                    men[i] = ($urandom % 5) != 0;
                end
                load_cfg();
                idle();
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule